// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block steers a physical memory address to one of a small set of chip selects. Each chip select owns a bounds register. The register holds a first and a last region index, and both count in 16 MiB units. A lookup compares the unit index of the incoming address against every populated window in parallel. It then returns a one-hot select with a hit flag, or an out-of-range flag when no window claims the address.

The bounds registers are loaded through a simple write port, one chip select per write. The block also publishes the size of every window, in 16 MiB units, so that neighbouring logic can total the installed memory without reading the registers. A window whose two indices are equal counts as unpopulated. A window whose first index lies above its last is empty. Neither kind ever claims an address, and both report a size of zero. When windows overlap, the lowest-numbered chip select wins.

Top module: `cs_addr_decoder`

## Requirements
- R1: After reset every bounds register reads as zero, so every chip select is unpopulated: `res_valid` is 0, every region size is 0, and every lookup ends out of range.
- R2: A write with `cfg_we` high loads `cfg_wdata[31:16]` as the first unit index and `cfg_wdata[15:0]` as the last unit index of chip select `cfg_sel`. The new values are used from the next cycle on. The other chip selects keep their bounds.
- R3: The unit index of an address is `lk_addr[39:24]`. A populated chip select claims every address whose unit index lies between its first and last index, both ends included. Its window therefore reaches up to last×2^24 + 2^24 − 1.
- R4: A chip select whose first index equals its last index is unpopulated and never claims an address, even one in that unit.
- R5: A chip select whose first index is greater than its last index never claims an address.
- R6: When no chip select claims the address, `res_oor` is 1, `res_hit` is 0 and `res_sel` is all zeros.
- R7: When several chip selects claim the address, only the lowest-numbered one is selected. Bit i of `res_sel` stands for chip select i.
- R8: A result appears one cycle after the lookup: `res_valid` is high in exactly the cycle after each cycle with `lk_valid` high. While `res_valid` is low, `res_sel`, `res_hit` and `res_oor` are zero.
- R9: `region_size[17*i+16 : 17*i]` holds last − first + 1 for chip select i when first < last, and zero otherwise. It tracks the registers with no lookup needed.
- R10: While `res_valid` is high, exactly one of `res_hit` and `res_oor` is 1, and `res_sel` has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Bounds register write strobe |
| cfg_sel | input | 2 | Chip select whose bounds are written |
| cfg_wdata | input | 32 | First index in [31:16], last index in [15:0] |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 40 | Physical address to decode |
| res_valid | output | 1 | Lookup result present |
| res_sel | output | 4 | One-hot chip select |
| res_hit | output | 1 | Some chip select claimed the address |
| res_oor | output | 1 | No chip select claimed the address |
| region_size | output | 68 | Four 17-bit window sizes in 16 MiB units |

## Verification
The hardest case to reach is an address claimed by more than one window. This needs overlapping bounds that are then rearranged, so that the lowest claimant changes between lookups. The stimulus first places disjoint windows and probes both edges of each unit range. It then rewrites one chip select to overlap two others, and turns the lowest one into an unpopulated window. The same address must then move to the next claimant. A final full-span window checks the largest size value, and back-to-back lookups check the one-cycle latency.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

   // Width of an index able to address n entries (never below one bit).
   function automatic int idx_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // Outcome class of one lookup, used for readability in the output stage.
   typedef enum logic [1:0] {
      CSD_IDLE = 2'b00,
      CSD_HIT  = 2'b01,
      CSD_MISS = 2'b10
   } csd_kind_e;

endpackage

// File: rtl/cs_bounds_regs.sv
module cs_bounds_regs #(
   parameter int NUM_CS  = 4,
   parameter int FIELD_W = 16,
   parameter int SEL_W   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [SEL_W-1:0]                sel,
   input  logic [2*FIELD_W-1:0]            wdata,
   output logic [NUM_CS-1:0][FIELD_W-1:0]  first_q,
   output logic [NUM_CS-1:0][FIELD_W-1:0]  last_q
);

   localparam int REG_W = 2 * FIELD_W;

   if (NUM_CS > (1 << SEL_W)) begin : g_bad_sel
      $error("cs_bounds_regs: SEL_W too narrow for NUM_CS");
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_entry
      logic hit_wr;
      assign hit_wr = we && (sel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            first_q[i] <= '0;
            last_q[i]  <= '0;
         end else if (hit_wr) begin
            first_q[i] <= wdata[REG_W-1:FIELD_W];
            last_q[i]  <= wdata[FIELD_W-1:0];
         end
      end

      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (we && sel == SEL_W'(i)) |=> (first_q[i] == $past(wdata[REG_W-1:FIELD_W])
                                     && last_q[i] == $past(wdata[FIELD_W-1:0]))); // R2
      AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && sel == SEL_W'(i)) |=> ($stable(first_q[i]) && $stable(last_q[i]))); // R2
   end

endmodule

// File: rtl/cs_range_match.sv
module cs_range_match #(
   parameter int FIELD_W = 16,
   parameter int SIZE_W  = FIELD_W + 1
) (
   input  logic [FIELD_W-1:0] first_idx,
   input  logic [FIELD_W-1:0] last_idx,
   input  logic [FIELD_W-1:0] key,
   input  logic               key_ok,
   output logic               claim,
   output logic [SIZE_W-1:0]  size
);

   if (SIZE_W < FIELD_W + 1) begin : g_bad_size
      $error("cs_range_match: SIZE_W cannot hold a full-span window");
   end

   logic populated;
   logic above_first;
   logic below_last;

   assign populated   = (first_idx != last_idx);
   assign above_first = (key >= first_idx);
   assign below_last  = (key <= last_idx);
   assign claim       = key_ok && populated && above_first && below_last;

   always_comb begin
      if (first_idx < last_idx)
         size = SIZE_W'(last_idx) - SIZE_W'(first_idx) + SIZE_W'(1);
      else
         size = '0;
   end

endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);

   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/cs_addr_decoder.sv
module cs_addr_decoder
   import cs_dec_pkg::*;
#(
   parameter int NUM_CS     = 4,
   parameter int ADDR_W     = 40,
   parameter int FIELD_W    = 16,
   parameter int GRAN_SHIFT = 24,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [idx_w(NUM_CS)-1:0]      cfg_sel,
   input  logic [2*FIELD_W-1:0]          cfg_wdata,
   input  logic                          lk_valid,
   input  logic [ADDR_W-1:0]             lk_addr,
   output logic                          res_valid,
   output logic [NUM_CS-1:0]             res_sel,
   output logic                          res_hit,
   output logic                          res_oor,
   output logic [NUM_CS*(FIELD_W+1)-1:0] region_size
);

   localparam int SEL_W   = idx_w(NUM_CS);
   localparam int SIZE_W  = FIELD_W + 1;
   localparam int KEY_LSB = GRAN_SHIFT;
   localparam int KEY_MSB = GRAN_SHIFT + FIELD_W - 1;

   if (NUM_CS < 1) begin : g_bad_cs
      $error("cs_addr_decoder: NUM_CS must be at least one");
   end
   if (ADDR_W < KEY_MSB + 1) begin : g_bad_addr
      $error("cs_addr_decoder: address narrower than unit index field");
   end
   if (GRAN_SHIFT < 1) begin : g_bad_gran
      $error("cs_addr_decoder: GRAN_SHIFT must be positive");
   end

   logic [NUM_CS-1:0][FIELD_W-1:0] first_q;
   logic [NUM_CS-1:0][FIELD_W-1:0] last_q;
   logic [FIELD_W-1:0]             key;
   logic                           key_ok;
   logic [NUM_CS-1:0]              claim;
   logic [NUM_CS-1:0]              gnt;
   logic                           any_claim;
   logic                           unused_low;

   cs_bounds_regs #(
      .NUM_CS (NUM_CS),
      .FIELD_W(FIELD_W),
      .SEL_W  (SEL_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .first_q(first_q),
      .last_q (last_q)
   );

   assign key        = lk_addr[KEY_MSB:KEY_LSB];
   assign unused_low = ^lk_addr[KEY_LSB-1:0];

   // Address bits above the index field must be clear for any window to match.
   if (ADDR_W > KEY_MSB + 1) begin : g_upper_chk
      assign key_ok = ~|lk_addr[ADDR_W-1:KEY_MSB+1];
   end else begin : g_upper_none
      assign key_ok = 1'b1;
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      cs_range_match #(
         .FIELD_W(FIELD_W),
         .SIZE_W (SIZE_W)
      ) u_match (
         .first_idx(first_q[i]),
         .last_idx (last_q[i]),
         .key      (key),
         .key_ok   (key_ok),
         .claim    (claim[i]),
         .size     (region_size[i*SIZE_W +: SIZE_W])
      );

      AST_SIZE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         (first_q[i] >= last_q[i]) |-> (region_size[i*SIZE_W +: SIZE_W] == '0)); // R9
   end

   cs_prio_pick #(
      .N(NUM_CS)
   ) u_pick (
      .req(claim),
      .gnt(gnt),
      .any(any_claim)
   );

   csd_kind_e kind_d;
   always_comb begin
      if (!lk_valid)      kind_d = CSD_IDLE;
      else if (any_claim) kind_d = CSD_HIT;
      else                kind_d = CSD_MISS;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid <= 1'b0;
            res_sel   <= '0;
            res_hit   <= 1'b0;
            res_oor   <= 1'b0;
         end else begin
            res_valid <= lk_valid;
            res_sel   <= (kind_d == CSD_HIT) ? gnt : '0;
            res_hit   <= (kind_d == CSD_HIT);
            res_oor   <= (kind_d == CSD_MISS);
         end
      end

      AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         lk_valid |=> res_valid); // R8
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         !lk_valid |=> !res_valid); // R8
      AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (lk_valid && claim[0]) |=> res_sel[0]); // R7
   end else begin : g_out_comb
      assign res_valid = lk_valid;
      assign res_sel   = (kind_d == CSD_HIT) ? gnt : '0;
      assign res_hit   = (kind_d == CSD_HIT);
      assign res_oor   = (kind_d == CSD_MISS);
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_unpop_chk
      if (OUT_REG) begin : g_reg
         AST_UNPOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_valid && first_q[i] == last_q[i]) |=> !res_sel[i]); // R4
      end
   end

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_sel)); // R10
   AST_HIT_XOR_OOR: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hit != res_oor)); // R10
   AST_OOR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      res_oor |-> (res_sel == '0)); // R6
   AST_HIT_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> ($countones(res_sel) == 1)); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_hit && !res_oor && res_sel == '0)); // R8

endmodule

// File: tb/cs_addr_decoder_tb.sv
`timescale 1ns/1ps
module cs_addr_decoder_tb;

   localparam int NCS = 4;
   localparam int SW  = 17;

   typedef struct {
      logic [3:0] sel;
      logic       hit;
      logic       oor;
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        lk_valid = 1'b0;
   logic [39:0] lk_addr = '0;
   logic        res_valid;
   logic [3:0]  res_sel;
   logic        res_hit;
   logic        res_oor;
   logic [NCS*SW-1:0] region_size;

   int checks = 0;
   int fails  = 0;
   exp_t sb[$];
   logic [15:0] m_first [NCS];
   logic [15:0] m_last  [NCS];
   bit done = 1'b0;

   always #4 clk = ~clk;

   cs_addr_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .res_valid(res_valid), .res_sel(res_sel), .res_hit(res_hit),
      .res_oor(res_oor), .region_size(region_size)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_bounds(input int cs, input logic [15:0] f, input logic [15:0] l);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(cs); cfg_wdata = {f, l};
      @(negedge clk);
      cfg_we = 1'b0;
      m_first[cs] = f;
      m_last[cs]  = l;
   endtask

   function automatic exp_t model(input logic [39:0] a, input string req);
      exp_t e;
      logic [15:0] k;
      k = a[39:24];
      e.sel = '0; e.hit = 1'b0; e.oor = 1'b1; e.req = req;
      for (int i = 0; i < NCS; i++) begin
         if (!e.hit && m_first[i] != m_last[i] && k >= m_first[i] && k <= m_last[i]) begin
            e.sel[i] = 1'b1; e.hit = 1'b1; e.oor = 1'b0;
         end
      end
      return e;
   endfunction

   // Driver: one lookup per call; keep_on leaves lk_valid high for back-to-back use.
   task automatic lookup(input logic [39:0] a, input string req, input bit keep_on);
      if (!lk_valid) @(negedge clk);
      lk_valid = 1'b1; lk_addr = a;
      sb.push_back(model(a, req));
      @(negedge clk);
      if (!keep_on) lk_valid = 1'b0;
   endtask

   function automatic logic [16:0] exp_size(input int i);
      if (m_first[i] < m_last[i]) return 17'(m_last[i]) - 17'(m_first[i]) + 17'd1;
      return '0;
   endfunction

   task automatic chk_sizes(input string req);
      @(negedge clk);
      for (int i = 0; i < NCS; i++)
         chk(region_size[i*SW +: SW] == exp_size(i), req, $sformatf("size cs%0d", i),
             64'(region_size[i*SW +: SW]), 64'(exp_size(i)));
   endtask

   // Monitor: pops expected results as the design produces them.
   always @(negedge clk) begin
      if (rst_n) begin
         if (res_valid) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R8", "result without lookup", 64'(res_sel), 64'h0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(res_sel == e.sel, e.req, "sel", 64'(res_sel), 64'(e.sel));
               chk(res_hit == e.hit && res_oor == e.oor, e.req, "hit/oor",
                   64'({res_hit, res_oor}), 64'({e.hit, e.oor}));
            end
         end else begin
            chk(!res_hit && !res_oor && res_sel == '0, "R8", "idle outputs",
                64'({res_sel, res_hit, res_oor}), 64'h0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R8", "watchdog expired", 64'h0, 64'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCS; i++) begin m_first[i] = '0; m_last[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(res_valid == 1'b0, "R1", "res_valid after reset", 64'(res_valid), 64'h0);
      chk_sizes("R1");
      lookup(40'h00_0000_0000, "R1", 1'b0);
      lookup(40'h00_0500_0000, "R1", 1'b0);

      // R2/R9: disjoint windows, one unpopulated, one inverted
      wr_bounds(0, 16'h0000, 16'h0003);
      wr_bounds(1, 16'h0004, 16'h0007);
      wr_bounds(2, 16'h0010, 16'h0010);
      wr_bounds(3, 16'h0020, 16'h001F);
      chk_sizes("R9");

      // R3: inclusive edges
      lookup(40'h00_0000_0000, "R3", 1'b0);
      lookup(40'h00_03FF_FFFF, "R3", 1'b0);
      lookup(40'h00_0400_0000, "R3", 1'b0);
      lookup(40'h00_07FF_FFFF, "R3", 1'b0);
      // R6: outside every window
      lookup(40'h00_0800_0000, "R6", 1'b0);
      lookup(40'hFF_FF00_0000, "R6", 1'b0);
      // R4: unpopulated unit
      lookup(40'h00_1000_0000, "R4", 1'b0);
      lookup(40'h00_10FF_FFFF, "R4", 1'b0);
      // R5: inverted window
      lookup(40'h00_1F00_0000, "R5", 1'b0);
      lookup(40'h00_2000_0000, "R5", 1'b0);

      // R7: overlapping windows
      wr_bounds(3, 16'h0002, 16'h0005);
      lookup(40'h00_0200_0000, "R7", 1'b0);
      lookup(40'h00_0500_0000, "R7", 1'b0);
      wr_bounds(0, 16'h0009, 16'h0009);
      lookup(40'h00_0200_0000, "R7", 1'b0);
      lookup(40'h00_0300_0000, "R7", 1'b0);
      chk_sizes("R2");

      // R9/R3: full-span window
      wr_bounds(2, 16'h0000, 16'hFFFF);
      chk_sizes("R9");
      lookup(40'hFF_FFFF_FFFF, "R3", 1'b0);
      lookup(40'h00_0000_0000, "R7", 1'b0);

      // R8/R10: back-to-back lookups
      lookup(40'h00_0100_0000, "R8", 1'b1);
      lookup(40'h00_0600_0000, "R8", 1'b1);
      lookup(40'h00_0900_0000, "R10", 1'b1);
      lookup(40'h00_4000_0000, "R10", 1'b0);

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R8", "results outstanding", 64'(sb.size()), 64'h0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule